// File: doc/BRIEF.md
# Pipelined Flash Command Sequencer

This block sequences program and erase work on a flash array. A host first sets a timebase divider and then hands over commands, each an opcode with an address and a data word. The accepted command sits in a one-entry staging buffer. From there the execution engine takes it into its own active register. The two registers act as a two-deep queue, so the host can stage the next command while the current one is still pulsing the array.

Every phase of an operation is counted in ticks of a slow timing enable. The divider derives that enable from the block clock, with an optional extra division by eight. When a word program ends and the staged command programs a word in the same row, the engine goes straight into the next pulse. The high-voltage enable stays on and the ramp-down and ramp-up are skipped.

The block gives two status flags, buffer-empty and all-done, and a maskable interrupt built from them. It also keeps a sticky access-error flag and a blank result for erase-verify.

Top module: `flash_cmd_seq`

## Requirements
- R1: Once the divider is written, `fclk_tick` pulses for one cycle every (F+1)×(P?8:1) clock cycles, where F is `div_val[5:0]` and P is `div_val[6]`.
- R2: A command offered before the first divider write is dropped and sets `acc_err`. The array sees no activity.
- R3: Legal opcodes are 1 word program, 2 sector erase, 3 mass erase and 4 erase-verify. Any other opcode, or any command offered while the staging buffer is full, is dropped and sets `acc_err`. A pulse on `err_clr` clears the flag.
- R4: `buf_empty` is low from the cycle after a command is accepted until the engine takes it. A second command is accepted while the first is executing.
- R5: A word program holds `hv_en` high for 5 ramp, 6 pulse and 2 ramp-down ticks, 13 ticks in all. It gives one `arr_prog` strobe carrying the command's address and data.
- R6: A sector erase holds `hv_en` for 5+20+2 ticks and strobes `arr_erase` with the command address. The sector is the address bits above the low 4. A mass erase has the same timing and strobes `arr_erase_all`.
- R7: A word program followed by a staged word program in the same row keeps `hv_en` high for 5+6+6+2 = 19 ticks in total. The row is the address bits above the low 3. If the rows differ, the two programs take 13+13 ticks.
- R8: Erase-verify reads the 16 words of the addressed sector, one per tick, with `hv_en` low. At the end `blank` is 1 only if every word read was all ones.
- R9: `all_done` is high exactly when the buffer is empty and the engine is idle.
- R10: `irq` equals (`ie_empty` AND `buf_empty`) OR (`ie_done` AND `all_done`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_we | input | 1 | Divider write strobe |
| div_val | input | 7 | Bit 6 prescale-by-8, bits 5:0 divide field |
| cmd_valid | input | 1 | Command launch strobe |
| cmd_op | input | 3 | Opcode |
| cmd_addr | input | AW | Command address |
| cmd_data | input | DW | Program data |
| err_clr | input | 1 | Clears the access-error flag |
| ie_empty | input | 1 | Interrupt enable for buffer-empty |
| ie_done | input | 1 | Interrupt enable for all-done |
| arr_rdata | input | DW | Array read data, valid in the cycle of `arr_rd` |
| fclk_tick | output | 1 | Divided timing enable |
| buf_empty | output | 1 | Staging buffer empty |
| all_done | output | 1 | No command staged or running |
| acc_err | output | 1 | Sticky access error |
| blank | output | 1 | Result of the last erase-verify |
| irq | output | 1 | Interrupt request |
| hv_en | output | 1 | High-voltage enable |
| arr_prog | output | 1 | Program-word strobe |
| arr_erase | output | 1 | Sector-erase strobe |
| arr_erase_all | output | 1 | Whole-array erase strobe |
| arr_rd | output | 1 | Verify read strobe |
| arr_addr | output | AW | Array address |
| arr_wdata | output | DW | Array program data |

## Verification
Some properties are checked on every cycle:
- the spacing of the timing enable;
- the access-error response to rejected launches;
- that the staging buffer holds its contents until taken;
- that array strobes are mutually exclusive, that program strobes fall inside high voltage and verify reads outside it;
- that high voltage survives a same-row chain;
- the interrupt mask.

Phase lengths in ticks, row-match decisions, the blank verdict over a whole sector, and the array contents left behind by mixed random command streams depend on whole scenarios. Only the bench's scenarios can show them.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam logic [2:0] OP_PROG   = 3'd1;
  localparam logic [2:0] OP_SERASE = 3'd2;
  localparam logic [2:0] OP_MERASE = 3'd3;
  localparam logic [2:0] OP_VERIFY = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RAMP, ST_PULSE, ST_RAMPDN, ST_VERIFY
  } eng_state_e;

  function automatic int unsigned div_period(input logic pre8, input logic [5:0] fdiv);
    int unsigned base;
    base = int'(fdiv) + 1;
    return pre8 ? base * 8 : base;
  endfunction

  function automatic logic op_legal(input logic [2:0] op);
    return (op == OP_PROG) || (op == OP_SERASE) || (op == OP_MERASE) || (op == OP_VERIFY);
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fcs_divider.sv
module fcs_divider #(
  parameter int FDIV_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_we,
  input  logic [FDIV_W:0]   div_val,
  output logic              div_set,
  output logic              tick
);
  import fcs_pkg::*;
  localparam int CNT_W = FDIV_W + 4;

  logic              set_q;
  logic [FDIV_W:0]   cfg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last;

  assign last    = CNT_W'(div_period(cfg_q[FDIV_W], 6'(cfg_q[FDIV_W-1:0])) - 1);
  assign tick    = set_q && (cnt_q == last);
  assign div_set = set_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= 1'b0;
      cfg_q <= '0;
      cnt_q <= '0;
    end else if (div_we) begin
      set_q <= 1'b1;
      cfg_q <= div_val;
      cnt_q <= '0;
    end else if (set_q) begin
      cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
    end
  end

  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !div_we && last != '0) |=> !tick);
endmodule

// File: rtl/fcs_queue.sv
module fcs_queue #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          div_set,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          err_clr,
  input  logic          pull,
  output logic          buf_v,
  output logic [2:0]    buf_op,
  output logic [AW-1:0] buf_addr,
  output logic [DW-1:0] buf_data,
  output logic          acc_err
);
  import fcs_pkg::*;

  logic accept, reject;
  assign accept = cmd_valid && div_set && !buf_v && op_legal(cmd_op);
  assign reject = cmd_valid && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_v    <= 1'b0;
      buf_op   <= '0;
      buf_addr <= '0;
      buf_data <= '0;
    end else if (accept) begin
      buf_v    <= 1'b1;
      buf_op   <= cmd_op;
      buf_addr <= cmd_addr;
      buf_data <= cmd_data;
    end else if (pull) begin
      buf_v    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_err <= 1'b0;
    else if (reject)  acc_err <= 1'b1;
    else if (err_clr) acc_err <= 1'b0;
  end

  p_nodiv_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !div_set) |=> acc_err);
  p_bad_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !op_legal(cmd_op)) |=> acc_err);
  p_buf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_v && !pull) |=> (buf_v && $stable(buf_addr) && $stable(buf_op)));
endmodule

// File: rtl/fcs_engine.sv
module fcs_engine #(
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int ROW_W   = 3,
  parameter int SECT_W  = 4,
  parameter int RAMP_T  = 5,
  parameter int PROG_T  = 6,
  parameter int ERASE_T = 20,
  parameter int DOWN_T  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          buf_v,
  input  logic [2:0]    buf_op,
  input  logic [AW-1:0] buf_addr,
  input  logic [DW-1:0] buf_data,
  input  logic [DW-1:0] arr_rdata,
  output logic          pull,
  output logic          idle,
  output logic          hv_en,
  output logic          blank,
  output logic          arr_prog,
  output logic          arr_erase,
  output logic          arr_erase_all,
  output logic          arr_rd,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata,
  output logic          chain
);
  import fcs_pkg::*;
  localparam int MAXT = max_of(max_of(RAMP_T, PROG_T), max_of(ERASE_T, DOWN_T));
  localparam int CW   = $clog2(MAXT + 1);

  eng_state_e          st_q;
  logic [CW-1:0]       cnt_q;
  logic [2:0]          op_q;
  logic [AW-1:0]       addr_q;
  logic [DW-1:0]       data_q;
  logic [SECT_W-1:0]   idx_q;
  logic                ok_q;
  logic                phase_end, pulse_end, same_row, last_word;

  function automatic logic [CW-1:0] pulse_len(input logic [2:0] op);
    return (op == OP_PROG) ? CW'(PROG_T - 1) : CW'(ERASE_T - 1);
  endfunction

  assign phase_end = tick && (cnt_q == '0);
  assign pulse_end = (st_q == ST_PULSE) && phase_end;
  assign same_row  = (buf_addr[AW-1:ROW_W] == addr_q[AW-1:ROW_W]);
  assign chain     = pulse_end && (op_q == OP_PROG) && buf_v && (buf_op == OP_PROG) && same_row;
  assign last_word = (idx_q == '1);
  assign idle      = (st_q == ST_IDLE);
  assign pull      = (idle && buf_v) || chain;

  assign hv_en         = (st_q == ST_RAMP) || (st_q == ST_PULSE) || (st_q == ST_RAMPDN);
  assign arr_prog      = pulse_end && (op_q == OP_PROG);
  assign arr_erase     = pulse_end && (op_q == OP_SERASE);
  assign arr_erase_all = pulse_end && (op_q == OP_MERASE);
  assign arr_rd        = (st_q == ST_VERIFY) && tick;
  assign arr_addr      = (st_q == ST_VERIFY) ? {addr_q[AW-1:SECT_W], idx_q} : addr_q;
  assign arr_wdata     = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      op_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
      idx_q  <= '0;
      ok_q   <= 1'b0;
      blank  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (buf_v) begin
          op_q   <= buf_op;
          addr_q <= buf_addr;
          data_q <= buf_data;
          idx_q  <= '0;
          ok_q   <= 1'b1;
          cnt_q  <= CW'(RAMP_T - 1);
          st_q   <= (buf_op == OP_VERIFY) ? ST_VERIFY : ST_RAMP;
        end
        ST_RAMP: if (phase_end) begin
          cnt_q <= pulse_len(op_q);
          st_q  <= ST_PULSE;
        end else if (tick) begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_PULSE: if (chain) begin
          op_q   <= buf_op;
          addr_q <= buf_addr;
          data_q <= buf_data;
          cnt_q  <= CW'(PROG_T - 1);
        end else if (phase_end) begin
          cnt_q <= CW'(DOWN_T - 1);
          st_q  <= ST_RAMPDN;
        end else if (tick) begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_RAMPDN: if (phase_end) begin
          st_q <= ST_IDLE;
        end else if (tick) begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_VERIFY: if (tick) begin
          if (last_word) begin
            blank <= ok_q && (arr_rdata == '1);
            st_q  <= ST_IDLE;
          end else begin
            ok_q  <= ok_q && (arr_rdata == '1);
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_prog_in_hv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_prog || arr_erase || arr_erase_all) |-> hv_en);
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_prog, arr_erase, arr_erase_all, arr_rd}));
  p_chain_keeps_hv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chain |=> hv_en);
  p_verify_no_hv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd |-> !hv_en);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int ROW_W   = 3,
  parameter int SECT_W  = 4,
  parameter int RAMP_T  = 5,
  parameter int PROG_T  = 6,
  parameter int ERASE_T = 20,
  parameter int DOWN_T  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          div_we,
  input  logic [6:0]    div_val,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          err_clr,
  input  logic          ie_empty,
  input  logic          ie_done,
  input  logic [DW-1:0] arr_rdata,
  output logic          fclk_tick,
  output logic          buf_empty,
  output logic          all_done,
  output logic          acc_err,
  output logic          blank,
  output logic          irq,
  output logic          hv_en,
  output logic          arr_prog,
  output logic          arr_erase,
  output logic          arr_erase_all,
  output logic          arr_rd,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata
);
  logic          div_set, pull, buf_v, eng_idle, chain;
  logic [2:0]    buf_op;
  logic [AW-1:0] buf_addr;
  logic [DW-1:0] buf_data;

  fcs_divider #(.FDIV_W(6)) u_div (
    .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_val(div_val),
    .div_set(div_set), .tick(fclk_tick)
  );

  fcs_queue #(.AW(AW), .DW(DW)) u_queue (
    .clk(clk), .rst_n(rst_n), .div_set(div_set), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .err_clr(err_clr), .pull(pull), .buf_v(buf_v), .buf_op(buf_op),
    .buf_addr(buf_addr), .buf_data(buf_data), .acc_err(acc_err)
  );

  fcs_engine #(.AW(AW), .DW(DW), .ROW_W(ROW_W), .SECT_W(SECT_W),
    .RAMP_T(RAMP_T), .PROG_T(PROG_T), .ERASE_T(ERASE_T), .DOWN_T(DOWN_T)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(fclk_tick), .buf_v(buf_v), .buf_op(buf_op),
    .buf_addr(buf_addr), .buf_data(buf_data), .arr_rdata(arr_rdata),
    .pull(pull), .idle(eng_idle), .hv_en(hv_en), .blank(blank),
    .arr_prog(arr_prog), .arr_erase(arr_erase), .arr_erase_all(arr_erase_all),
    .arr_rd(arr_rd), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .chain(chain)
  );

  assign buf_empty = !buf_v;
  assign all_done  = !buf_v && eng_idle;
  assign irq       = (ie_empty && buf_empty) || (ie_done && all_done);

  p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_empty && !ie_done) |-> !irq);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |-> (!hv_en && !arr_rd));
endmodule

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          div_we = 0, cmd_valid = 0, err_clr = 0, ie_empty = 0, ie_done = 0;
  logic [6:0]    div_val = '0;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic [DW-1:0] arr_rdata;
  logic fclk_tick, buf_empty, all_done, acc_err, blank, irq, hv_en;
  logic arr_prog, arr_erase, arr_erase_all, arr_rd;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;

  always #5 clk = ~clk;

  flash_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_val(div_val),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .err_clr(err_clr), .ie_empty(ie_empty), .ie_done(ie_done), .arr_rdata(arr_rdata),
    .fclk_tick(fclk_tick), .buf_empty(buf_empty), .all_done(all_done), .acc_err(acc_err),
    .blank(blank), .irq(irq), .hv_en(hv_en), .arr_prog(arr_prog), .arr_erase(arr_erase),
    .arr_erase_all(arr_erase_all), .arr_rd(arr_rd), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  // array model and event counters
  logic [DW-1:0] mem [256];
  logic [DW-1:0] exp_mem [256];
  int hv_ticks, n_prog, n_erase, n_rd;
  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_data;
  assign arr_rdata = mem[arr_addr];

  always @(negedge clk) begin
    if (hv_en && fclk_tick) hv_ticks++;
    if (arr_rd) n_rd++;
    if (arr_prog) begin
      n_prog++; last_addr = arr_addr; last_data = arr_wdata; mem[arr_addr] = arr_wdata;
    end
    if (arr_erase) begin
      n_erase++; last_addr = arr_addr;
      for (int i = 0; i < 16; i++) mem[{arr_addr[7:4], 4'(i)}] = '1;
    end
    if (arr_erase_all) begin
      n_erase++;
      for (int i = 0; i < 256; i++) mem[i] = '1;
    end
  end

  int tests = 0, fails = 0;
  bit finished = 0;

  function automatic int exp_period(input logic pre, input logic [5:0] f);
    return pre ? (f + 1) << 3 : f + 1;
  endfunction
  function automatic int exp_hv(input logic [2:0] op, input bit chained);
    if (op == 3'd1) return chained ? 5 + 6 + 6 + 2 : 5 + 6 + 2;
    return 5 + 20 + 2;
  endfunction
  function automatic logic exp_blank(input logic [3:0] sect);
    logic b = 1'b1;
    for (int i = 0; i < 16; i++) if (exp_mem[{sect, 4'(i)}] != '1) b = 1'b0;
    return b;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_div(input logic [6:0] v);
    @(negedge clk); div_we = 1; div_val = v;
    @(negedge clk); div_we = 0;
  endtask

  task automatic send(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic wait_idle();
    while (!all_done) @(negedge clk);
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
  endtask

  task automatic model_op(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d);
    if (op == 3'd1) exp_mem[a] = d;
    else if (op == 3'd2) for (int i = 0; i < 16; i++) exp_mem[{a[7:4], 4'(i)}] = '1;
    else if (op == 3'd3) for (int i = 0; i < 256; i++) exp_mem[i] = '1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin mem[i] = 16'h0; exp_mem[i] = 16'h0; end
    hv_ticks = 0; n_prog = 0; n_erase = 0; n_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R9, R4)
    chk(buf_empty && all_done && !acc_err && !hv_en && !irq, "R9 reset", {buf_empty, all_done, acc_err, hv_en}, 4'b1100);

    // R2: launch before divider written
    send(3'd1, 8'h10, 16'h1234);
    repeat (40) @(negedge clk);
    chk(acc_err == 1, "R2 acc_err", acc_err, 1);
    chk(n_prog == 0 && hv_ticks == 0 && buf_empty, "R2 no activity", n_prog + hv_ticks, 0);
    clear_err();
    chk(acc_err == 0, "R3 err clear", acc_err, 0);

    // R1: divider periods, random and corner values
    for (int k = 0; k < 6; k++) begin
      logic pre; logic [5:0] f; int cnt;
      pre = (k == 0) ? 1'b0 : 1'($urandom_range(0, 1));
      f = (k == 0) ? 6'd0 : 6'($urandom_range(0, 9));
      set_div({pre, f});
      while (!fclk_tick) @(negedge clk);
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (!fclk_tick);
      chk(cnt == exp_period(pre, f), "R1 period", cnt, exp_period(pre, f));
    end
    set_div({1'b0, 6'd1});

    // R3: illegal opcodes
    foreach (cmd_op[i]) ;
    send(3'd0, 8'h0, 16'h0);
    @(negedge clk);
    chk(acc_err && buf_empty, "R3 opcode 0", acc_err, 1);
    clear_err();
    send(3'd6, 8'h0, 16'h0);
    @(negedge clk);
    chk(acc_err && buf_empty, "R3 opcode 6", acc_err, 1);
    clear_err();

    // R6 mass erase, with interrupt checks (R10)
    ie_empty = 0; ie_done = 1;
    hv_ticks = 0; n_erase = 0;
    send(3'd3, 8'h00, 16'h0); model_op(3'd3, 0, 0);
    repeat (4) @(negedge clk);
    chk(irq == 0, "R10 done-only masked while busy", irq, 0);
    ie_empty = 1;
    @(negedge clk);
    chk(irq == 1, "R10 empty enable", irq, 1);
    ie_empty = 0;
    wait_idle();
    @(negedge clk);
    chk(irq == 1 && all_done, "R10 done enable", irq, 1);
    chk(hv_ticks == exp_hv(3'd3, 0), "R6 mass erase ticks", hv_ticks, exp_hv(3'd3, 0));
    chk(n_erase == 1, "R6 erase strobe", n_erase, 1);
    ie_done = 0;
    @(negedge clk);
    chk(irq == 0, "R10 all masked", irq, 0);

    // R8 verify blank sector
    hv_ticks = 0; n_rd = 0;
    send(3'd4, 8'h25, 16'h0);
    wait_idle();
    chk(blank == exp_blank(4'h2), "R8 blank sector", blank, exp_blank(4'h2));
    chk(n_rd == 16 && hv_ticks == 0, "R8 reads no hv", n_rd, 16);

    // R5 random programs
    for (int k = 0; k < 12; k++) begin
      logic [7:0] a; logic [15:0] d;
      a = 8'($urandom); d = 16'($urandom_range(0, 16'hfffe));
      hv_ticks = 0; n_prog = 0;
      send(3'd1, a, d); model_op(3'd1, a, d);
      wait_idle();
      chk(hv_ticks == exp_hv(3'd1, 0), "R5 prog ticks", hv_ticks, exp_hv(3'd1, 0));
      chk(n_prog == 1 && last_addr == a && last_data == d, "R5 prog strobe", last_data, d);
    end

    // R8 verify non-blank sector of last write, and blank verdict per model
    send(3'd4, {cmd_addr[7:4], 4'h0}, 16'h0);
    wait_idle();
    chk(blank == exp_blank(cmd_addr[7:4]), "R8 verdict", blank, exp_blank(cmd_addr[7:4]));

    // R6 sector erase then verify
    hv_ticks = 0; n_erase = 0;
    send(3'd2, 8'h73, 16'h0); model_op(3'd2, 8'h73, 0);
    wait_idle();
    chk(hv_ticks == exp_hv(3'd2, 0) && n_erase == 1 && last_addr == 8'h73, "R6 sector erase", hv_ticks, exp_hv(3'd2, 0));
    send(3'd4, 8'h70, 16'h0);
    wait_idle();
    chk(blank == 1, "R8 erased sector blank", blank, 1);

    // R7 / R4 back-to-back pairs, random same or different row
    for (int k = 0; k < 8; k++) begin
      logic [7:0] a, b; logic [15:0] da, db; bit same;
      same = (k < 2) ? bit'(k == 0) : bit'($urandom_range(0, 1));
      a = 8'($urandom); da = 16'($urandom);
      b = same ? {a[7:3], 3'($urandom)} : {a[7:3] + 5'd1, 3'($urandom)};
      db = 16'($urandom);
      hv_ticks = 0; n_prog = 0;
      send(3'd1, a, da); model_op(3'd1, a, da);
      while (!buf_empty) @(negedge clk);
      send(3'd1, b, db); model_op(3'd1, b, db);
      chk(!acc_err && !buf_empty, "R4 staged while busy", acc_err, 0);
      if (k == 0) begin
        send(3'd1, 8'h00, 16'h0);
        chk(acc_err == 1, "R3 buffer full reject", acc_err, 1);
        clear_err();
      end
      wait_idle();
      chk(hv_ticks == (same ? exp_hv(3'd1, 1) : 2 * exp_hv(3'd1, 0)), "R7 chain ticks",
          hv_ticks, same ? exp_hv(3'd1, 1) : 2 * exp_hv(3'd1, 0));
      chk(n_prog == 2 && last_data == db, "R7 both programmed", n_prog, 2);
    end

    // final array compare
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
      chk(bad == 0, "R5 array contents", bad, 0);
    end
    chk(all_done && buf_empty && !hv_en, "R9 final idle", all_done, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule